// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a synthesizable model of a 32-bit-wide (four byte lanes) synchronous burst static RAM with its own storage array. Every address, data and control input except output enable, sleep and burst-order select is sampled on the rising clock edge. An access starts when one of two active-low address strobes is seen: the processor-side strobe or the controller-side strobe. Each strobe aborts any running burst, latches a fresh address and either selects the device for a read or write or deselects it. The two strobes follow different rules when the primary enable is inactive.

Once an access is open, the active-low advance input steps the two low address bits through a four-beat burst. The order is linear (wrapping increment) or interleaved (start XOR beat count), chosen by a level input that is high (interleaved) when not driven otherwise. Writes use either a global write, which covers all four lanes, or a lane-granular write with one enable per lane. Read data is registered one stage after the access cycle. It is flagged valid on `dout_en` only while output enable is low and the device is not asleep. A sleep input freezes all internal state and keeps the memory contents. After sleep is released, the device stays idle until a new strobe.

Top module: `sbsram_model`

## Requirements
- R1: An accepted address strobe aborts a running burst. The next access uses the newly latched address, and advancing continues from that address.
- R2: While `en1_n` is high, a low `stb_proc_n` is ignored: no address is latched and a running burst continues. A low `stb_ctl_n` in the same condition deselects the device. After that, `dout_en` stays low through later advance cycles.
- R3: A strobe selects the device only when `en1_n`=0, `en2`=1 and `en3_n`=0. Any other combination seen with an accepted strobe deselects it, so no read data is flagged.
- R4: With `order_il`=0, each cycle with `adv_n`=0 moves to the next beat. The low address bits are (start + k) mod 4 at beat k.
- R5: With `order_il`=1, the low address bits at beat k are start XOR k.
- R6: `gwr_n`=0 in a write-allowed cycle writes all four bytes of `din`, regardless of `wr_n` and `bwe_n`.
- R7: With `gwr_n`=1 and `wr_n`=0, only lane i (bits 8i+7..8i) for which `bwe_n[i]`=0 is written. With `gwr_n`=1 and `wr_n`=1, the cycle is a read.
- R8: Read data for the access sampled at edge n appears on `dout` after edge n. `dout_en` is high only for a selected read and is forced low at once while `oe_n` is high.
- R9: While `sleep` is high, no write occurs and `dout_en` is low. After release, the device stays idle, even with `adv_n` or write controls active, until a strobe starts a new access. Memory contents are kept.
- R10: When both strobes are low and `en1_n`=0, the processor strobe wins, so that access is a read even if write controls are active.
- R11: The cycle that a processor strobe starts is always a read. Write controls take effect in the following burst cycles at the latched address, including cycles with `adv_n`=1.
- R12: In an open access, a cycle with `adv_n`=1 and no strobe repeats the current address.
- R13: After synchronous reset, the device is idle and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_ctl_n | input | 1 | Controller address strobe, active low |
| stb_proc_n | input | 1 | Processor address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Primary chip enable, active low |
| en2 | input | 1 | Second chip enable, active high |
| en3_n | input | 1 | Third chip enable, active low |
| gwr_n | input | 1 | Global write, all lanes, active low |
| wr_n | input | 1 | Lane write, active low |
| bwe_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| order_il | input | 1 | Burst order: 1 interleaved (default), 0 linear |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data |
| dout | output | 32 | Registered read data |
| dout_en | output | 1 | Read data valid and output enabled |

## Verification
The bench builds the block with `ADDR_W`=4, a sixteen-word array. At this size every word is written with a global write and read back. All sixteen lane-enable patterns are applied to one word, and every start offset is taken through a full burst in both orders. A small array lets the bench hold a complete shadow memory, so expected read data is computed for every address the design can reach. The enable combinations, the strobe contention cases and the sleep entry and exit are then driven against that shadow.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned WORD_W = LANES * LANE_W;
    localparam int unsigned BEAT_W = 2;

    typedef enum logic [1:0] {
        STB_NONE = 2'd0,
        STB_PROC = 2'd1,
        STB_CTL  = 2'd2
    } strobe_e;

    typedef struct packed {
        logic              active;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
    } burst_t;

    function automatic logic [BEAT_W-1:0] beat_lsb(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              il
    );
        return il ? (start ^ beat) : (start + beat);
    endfunction

    function automatic strobe_e pick_strobe(
        input logic ctl_n,
        input logic proc_n,
        input logic en1_n
    );
        if (!proc_n && !en1_n) return STB_PROC;
        if (!ctl_n)            return STB_CTL;
        return STB_NONE;
    endfunction

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic              stb_ctl_n,
    input  logic              stb_proc_n,
    input  logic              adv_n,
    input  logic              en1_n,
    input  logic              en2,
    input  logic              en3_n,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_valid,
    output logic              acc_wr_ok,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int unsigned HI_W = ADDR_W - BEAT_W;

    burst_t          st, st_nxt;
    logic [HI_W-1:0] base_hi, base_hi_nxt;
    logic            selected;
    strobe_e         kind;
    logic [BEAT_W-1:0] beat_nxt;

    always_comb begin
        kind        = pick_strobe(stb_ctl_n, stb_proc_n, en1_n);
        selected    = !en1_n && en2 && !en3_n;
        st_nxt      = st;
        base_hi_nxt = base_hi;
        acc_valid   = 1'b0;
        acc_wr_ok   = 1'b0;
        acc_addr    = addr;
        beat_nxt    = st.beat;
        if (sleep) begin
            st_nxt.active = 1'b0;
        end else if (kind != STB_NONE) begin
            base_hi_nxt   = addr[ADDR_W-1:BEAT_W];
            st_nxt.start  = addr[BEAT_W-1:0];
            st_nxt.beat   = '0;
            st_nxt.active = selected;
            acc_valid     = selected;
            acc_wr_ok     = (kind == STB_CTL);
        end else if (st.active) begin
            beat_nxt    = adv_n ? st.beat : st.beat + 1'b1;
            st_nxt.beat = beat_nxt;
            acc_valid   = 1'b1;
            acc_wr_ok   = 1'b1;
            acc_addr    = {base_hi, beat_lsb(st.start, beat_nxt, order_il)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            base_hi <= '0;
        end else begin
            st      <= st_nxt;
            base_hi <= base_hi_nxt;
        end
    end

    assert_proc_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (!sleep && en1_n && stb_ctl_n) |=> $stable(base_hi));

    assert_deselect_R3: assert property (@(posedge clk) disable iff (rst)
        (!sleep && (!stb_ctl_n || (!stb_proc_n && !en1_n)) && !(en2 && !en3_n))
            |=> !st.active);

    assert_sleep_idle_R9: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !st.active);

    assert_hold_beat_R12: assert property (@(posedge clk) disable iff (rst)
        (!sleep && st.active && adv_n && stb_ctl_n && (stb_proc_n || en1_n))
            |=> $stable(st.beat));

endmodule

// File: rtl/sbsram_lanes.sv
module sbsram_lanes
    import sbsram_pkg::*;
(
    input  logic             acc_valid,
    input  logic             acc_wr_ok,
    input  logic             gwr_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] bwe_n,
    output logic [LANES-1:0] we,
    output logic             rd
);

    logic wr_cycle;

    assign wr_cycle = acc_valid && acc_wr_ok && (!gwr_n || !wr_n);
    assign rd       = acc_valid && !wr_cycle;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign we[i] = wr_cycle && (!gwr_n || !bwe_n[i]);
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LANES-1:0]  we,
    input  logic              rd,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < LANES; i++) begin : g_wlane
        always_ff @(posedge clk) begin
            if (we[i]) begin
                mem[acc_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rd) begin
            rdata <= mem[acc_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rvalid <= 1'b0;
        else     rvalid <= rd;
    end

endmodule

// File: rtl/sbsram_model.sv
module sbsram_model
    import sbsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_ctl_n,
    input  logic              stb_proc_n,
    input  logic              adv_n,
    input  logic              en1_n,
    input  logic              en2,
    input  logic              en3_n,
    input  logic              gwr_n,
    input  logic              wr_n,
    input  logic [3:0]        bwe_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic              order_il = 1'b1,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       din,
    output logic [31:0]       dout,
    output logic              dout_en
);

    logic              acc_valid;
    logic              acc_wr_ok;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  we;
    logic              rd;
    logic              rvalid;

    sbsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sleep     (sleep),
        .stb_ctl_n (stb_ctl_n),
        .stb_proc_n(stb_proc_n),
        .adv_n     (adv_n),
        .en1_n     (en1_n),
        .en2       (en2),
        .en3_n     (en3_n),
        .order_il  (order_il),
        .addr      (addr),
        .acc_valid (acc_valid),
        .acc_wr_ok (acc_wr_ok),
        .acc_addr  (acc_addr)
    );

    sbsram_lanes u_lanes (
        .acc_valid(acc_valid),
        .acc_wr_ok(acc_wr_ok),
        .gwr_n    (gwr_n),
        .wr_n     (wr_n),
        .bwe_n    (bwe_n),
        .we       (we),
        .rd       (rd)
    );

    sbsram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .acc_addr(acc_addr),
        .we      (we),
        .rd      (rd),
        .din     (din),
        .rdata   (dout),
        .rvalid  (rvalid)
    );

    assign dout_en = rvalid && !oe_n && !sleep;

    assert_proc_start_read_R11: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !stb_proc_n && !en1_n) |-> (we == '0));

    assert_sleep_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (we == '0));

endmodule

// File: tb/test_sbsram_model.sv
module test_sbsram_model;

    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stb_ctl_n = 1'b1, stb_proc_n = 1'b1, adv_n = 1'b1;
    logic en1_n = 1'b0, en2 = 1'b1, en3_n = 1'b0;
    logic gwr_n = 1'b1, wr_n = 1'b1;
    logic [3:0] bwe_n = 4'hF;
    logic oe_n = 1'b0, sleep = 1'b0, order_il = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic dout_en;

    logic [31:0] shadow [16];
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sbsram_model #(.ADDR_W(AW)) i_sbsram_model (
        .clk(clk), .rst(rst), .stb_ctl_n(stb_ctl_n), .stb_proc_n(stb_proc_n),
        .adv_n(adv_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
        .gwr_n(gwr_n), .wr_n(wr_n), .bwe_n(bwe_n), .oe_n(oe_n),
        .sleep(sleep), .order_il(order_il), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_read(input string req, input logic [31:0] exp);
        chk(dout_en === 1'b1, req, {31'd0, dout_en}, 32'd1);
        chk(dout === exp, req, dout, exp);
    endtask

    task automatic idle();
        stb_ctl_n = 1'b1; stb_proc_n = 1'b1; adv_n = 1'b1;
        en1_n = 1'b0; en2 = 1'b1; en3_n = 1'b0;
        gwr_n = 1'b1; wr_n = 1'b1; bwe_n = 4'hF; sleep = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ctl_access(input logic [AW-1:0] a);
        idle();
        stb_ctl_n = 1'b0;
        addr = a;
    endtask

    function automatic logic [31:0] pat(input int a);
        return (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F96;
    endfunction

    function automatic logic [1:0] lsb_of(input int s, input int k, input bit il);
        return il ? 2'(s ^ k) : 2'((s + k) % 4);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle();
        tick(); tick();
        rst = 1'b0;
        #1;
        // R13 reset state
        chk(dout_en === 1'b0, "R13", {31'd0, dout_en}, 32'd0);

        // R6 fill every word with a global write
        for (int a = 0; a < 16; a++) begin
            ctl_access(AW'(a));
            gwr_n = 1'b0; wr_n = 1'b1; bwe_n = 4'hF; din = pat(a);
            tick();
            shadow[a] = pat(a);
        end
        // R8 read back every word, one stage after the access edge
        for (int a = 0; a < 16; a++) begin
            ctl_access(AW'(a));
            tick();
            chk_read("R6_R8", shadow[a]);
        end

        // R8 output enable gates dout_en asynchronously
        oe_n = 1'b1; #1;
        chk(dout_en === 1'b0, "R8", {31'd0, dout_en}, 32'd0);
        oe_n = 1'b0; #1;
        chk(dout_en === 1'b1, "R8", {31'd0, dout_en}, 32'd1);

        // R7 every lane pattern on word 3, then a read cycle with wr_n high
        for (int p = 0; p < 16; p++) begin
            logic [31:0] nd;
            nd = ~pat(p + 40);
            ctl_access(AW'(3));
            wr_n = 1'b0; bwe_n = ~4'(p); din = nd;
            tick();
            for (int i = 0; i < 4; i++)
                if (p[i]) shadow[3][i*8 +: 8] = nd[i*8 +: 8];
            ctl_access(AW'(3));
            wr_n = 1'b1; bwe_n = 4'h0; din = 32'hFFFF_FFFF;
            tick();
            chk_read("R7", shadow[3]);
        end

        // R4 / R5 full bursts from every start offset in both orders
        for (int il = 0; il < 2; il++) begin
            order_il = il[0];
            for (int s = 0; s < 4; s++) begin
                ctl_access(AW'(4 + s));
                tick();
                chk_read(il ? "R5" : "R4", shadow[4 + s]);
                idle(); adv_n = 1'b0;
                for (int k = 1; k < 4; k++) begin
                    tick();
                    chk_read(il ? "R5" : "R4", shadow[4 + lsb_of(s, k, il[0])]);
                end
            end
        end

        // R12 hold address with adv_n high
        order_il = 1'b0;
        ctl_access(AW'(9));
        tick();
        idle(); adv_n = 1'b0; tick();
        chk_read("R12", shadow[10]);
        adv_n = 1'b1; tick();
        chk_read("R12", shadow[10]);

        // R1 abort a burst with a new strobe, then continue from it
        ctl_access(AW'(4)); tick();
        idle(); adv_n = 1'b0; tick();
        ctl_access(AW'(9)); tick();
        chk_read("R1", shadow[9]);
        idle(); adv_n = 1'b0; tick();
        chk_read("R1", shadow[10]);

        // R2 processor strobe ignored while en1_n high
        ctl_access(AW'(12)); tick();
        idle(); stb_proc_n = 1'b0; en1_n = 1'b1; addr = AW'(1); adv_n = 1'b0;
        tick();
        chk_read("R2", shadow[13]);
        // R2 controller strobe with en1_n high deselects
        idle(); stb_ctl_n = 1'b0; en1_n = 1'b1; addr = AW'(2); tick();
        chk(dout_en === 1'b0, "R2", {31'd0, dout_en}, 32'd0);
        idle(); adv_n = 1'b0; tick();
        chk(dout_en === 1'b0, "R2", {31'd0, dout_en}, 32'd0);

        // R3 enable combinations that deselect
        for (int c = 0; c < 3; c++) begin
            ctl_access(AW'(5)); tick();
            idle();
            if (c == 0) begin stb_ctl_n = 1'b0; en2 = 1'b0; end
            if (c == 1) begin stb_ctl_n = 1'b0; en3_n = 1'b1; end
            if (c == 2) begin stb_proc_n = 1'b0; en2 = 1'b0; end
            addr = AW'(6);
            tick();
            chk(dout_en === 1'b0, "R3", {31'd0, dout_en}, 32'd0);
        end

        // R10 both strobes low: processor strobe wins, no write
        idle(); stb_ctl_n = 1'b0; stb_proc_n = 1'b0; addr = AW'(7);
        gwr_n = 1'b0; din = 32'hDEAD_BEEF;
        tick();
        chk_read("R10", shadow[7]);

        // R11 processor start reads, following cycle writes at same address
        idle(); stb_proc_n = 1'b0; addr = AW'(11); gwr_n = 1'b0; din = 32'h1234_5678;
        tick();
        chk_read("R11", shadow[11]);
        idle(); gwr_n = 1'b0; din = 32'h1234_5678;
        tick();
        shadow[11] = 32'h1234_5678;
        idle(); tick();
        chk_read("R11", shadow[11]);

        // R9 sleep during a burst: no write, no output, idle after release
        ctl_access(AW'(0)); tick();
        idle(); sleep = 1'b1; gwr_n = 1'b0; din = 32'h0BAD_F00D; adv_n = 1'b0;
        #1;
        chk(dout_en === 1'b0, "R9", {31'd0, dout_en}, 32'd0);
        tick();
        idle(); gwr_n = 1'b0; din = 32'h0BAD_F00D; adv_n = 1'b0;
        tick();
        chk(dout_en === 1'b0, "R9", {31'd0, dout_en}, 32'd0);
        idle(); tick();
        for (int a = 0; a < 4; a++) begin
            ctl_access(AW'(a)); tick();
            chk_read("R9", shadow[a]);
        end

        idle(); tick();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule